// File: doc/BRIEF.md
# Scratch Pad Register File with Selectable Address Source

This block is a small general register file for a microcoded datapath. It holds sixteen 16-bit words. The entry that is read and written is chosen, cycle by cycle, from one of four address sources:

- a 4-bit immediate address taken from the current microword;
- the 3-bit source register field of the instruction word;
- the 3-bit destination register field of the instruction word;
- the low three bits of the bus address register.

The microcode sets a 2-bit select and a write enable. When the write enable is set, the write data is stored into the selected entry at the clock edge. Otherwise every entry keeps its value.

The read side is combinational from the current address. It drives two views of the selected entry: the full word, and a byte view. The byte view passes bits 7:0 and forces bits 15:8 to zero, for datapath legs that work on bytes. The instruction word is taken as raw bits; no decoding is done here.

Top module: `scratch_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, every one of the 16 entries is cleared to zero.
- R2: With addr_sel = 0, the entry index is uw_addr[3:0], so all 16 entries are reachable.
- R3: With addr_sel = 1, the entry index is {1'b0, instr[8:6]}; all other instr bits have no effect on the index.
- R4: With addr_sel = 2, the entry index is {1'b0, instr[2:0]}; all other instr bits have no effect on the index.
- R5: With addr_sel = 3, the entry index is {1'b0, bus_addr[2:0]}; bus_addr[15:3] has no effect on the index.
- R6: When wr_en is 1 at a rising edge with rst_n high, wr_data is stored into the selected entry, and no other entry changes.
- R7: When wr_en is 0 at a rising edge, no entry changes, whatever the select, address and data inputs are.
- R8: rd_word shows the selected entry in the same cycle the address inputs change. A write becomes visible only after the edge that stores it.
- R9: rd_low equals {8'h00, rd_word[7:0]} at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 2 | Address source: 0 microword, 1 instr[8:6], 2 instr[2:0], 3 bus_addr[2:0] |
| uw_addr | input | 4 | Immediate entry index from the microword |
| instr | input | 16 | Instruction word (register fields only are used) |
| bus_addr | input | 16 | Bus address register value |
| wr_en | input | 1 | 1 stores wr_data at the selected entry on the edge |
| wr_data | input | 16 | Data to store |
| rd_word | output | 16 | Full selected entry |
| rd_low | output | 16 | Selected entry with bits 15:8 forced to zero |

## Verification
Every entry is filled through the microword source with a distinct pattern, so that a wrong index or a stuck address bit shows up as a mismatch on readback. Each 3-bit source is driven with its unused upper bits set to ones. A write through such a source must land in entries 0 to 7 and leave the entry eight above it untouched, which proves the zero-extension. Cycles with the write enable low use data and addresses that differ from the stored contents, so that a spurious write would be seen. A value with a non-zero upper byte, read on the same cycle a write is pending, separates the byte view from the full word and separates combinational reads from stored ones.

// File: rtl/spad_pkg.sv
// Package: shared types for the scratch pad register file.
// Assumes a 2-bit address-source select.
package spad_pkg;
    typedef enum logic [1:0] {
        SRC_UWORD  = 2'd0,
        SRC_IR_SRC = 2'd1,
        SRC_IR_DST = 2'd2,
        SRC_BUS    = 2'd3
    } spad_src_e;
endpackage

// File: rtl/spad_addr_mux.sv
// Module: spad_addr_mux
// Picks the register index from one of four sources.
// Assumes each 3-bit field is narrower than the index and zero-extends it.
module spad_addr_mux
    import spad_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FIELD_W = 3,
    parameter int IR_W    = 16,
    parameter int BA_W    = 16,
    parameter int SRC_LSB = 6,
    parameter int DST_LSB = 0
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] uw_addr,
    input  logic [IR_W-1:0]   instr,
    input  logic [BA_W-1:0]   bus_addr,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - FIELD_W;

    logic [ADDR_W-1:0] src_idx;
    logic [ADDR_W-1:0] dst_idx;
    logic [ADDR_W-1:0] bus_idx;

    // Zero-extend the narrow fields when the index is wider than them.
    generate
        if (PAD_W > 0) begin : g_pad
            assign src_idx = {{PAD_W{1'b0}}, instr[SRC_LSB +: FIELD_W]};
            assign dst_idx = {{PAD_W{1'b0}}, instr[DST_LSB +: FIELD_W]};
            assign bus_idx = {{PAD_W{1'b0}}, bus_addr[FIELD_W-1:0]};
        end else begin : g_nopad
            assign src_idx = instr[SRC_LSB +: ADDR_W];
            assign dst_idx = instr[DST_LSB +: ADDR_W];
            assign bus_idx = bus_addr[ADDR_W-1:0];
        end
    endgenerate

    // Four-way source selection.
    always_comb begin
        unique case (spad_src_e'(sel))
            SRC_UWORD:  addr = uw_addr;
            SRC_IR_SRC: addr = src_idx;
            SRC_IR_DST: addr = dst_idx;
            SRC_BUS:    addr = bus_idx;
            default:    addr = uw_addr;
        endcase
    end
endmodule

// File: rtl/spad_regfile.sv
// Module: spad_regfile
// Single-port register array with a combinational read and an
// edge-triggered write. A synchronous active-low reset clears all entries.
module spad_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Clear on reset; otherwise store at the selected entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    // Combinational read of the selected entry.
    assign rd_data = mem[addr];

    // R1: the array is all zero on leaving reset.
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem == '0));

    // R6: an enabled write lands at the address that was selected.
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (mem[$past(addr)] == $past(wr_data)));

    // R7: without enable, the whole array holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(mem));
endmodule

// File: rtl/spad_byte_view.sv
// Module: spad_byte_view
// Passes the low byte of a word and forces the upper bits to zero.
module spad_byte_view #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] low_out
);
    localparam int HIGH_W = DATA_W - LOW_W;

    // Keep the low byte and zero the rest.
    assign low_out = {{HIGH_W{1'b0}}, word_in[LOW_W-1:0]};
endmodule

// File: rtl/scratch_regfile.sv
// Module: scratch_regfile
// Top of the scratch pad: an address-source mux feeding a 16x16 register
// array, with full-word and low-byte read views.
// Assumes that instruction decoding is done elsewhere.
module scratch_regfile #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 3,
    parameter int IR_W    = 16,
    parameter int BA_W    = 16,
    parameter int LOW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_sel,
    input  logic [ADDR_W-1:0] uw_addr,
    input  logic [IR_W-1:0]   instr,
    input  logic [BA_W-1:0]   bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_low
);
    logic [ADDR_W-1:0] cur_addr;

    spad_addr_mux #(
        .ADDR_W (ADDR_W),
        .FIELD_W(FIELD_W),
        .IR_W   (IR_W),
        .BA_W   (BA_W),
        .SRC_LSB(6),
        .DST_LSB(0)
    ) u_mux (
        .sel     (addr_sel),
        .uw_addr (uw_addr),
        .instr   (instr),
        .bus_addr(bus_addr),
        .addr    (cur_addr)
    );

    spad_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (cur_addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_word)
    );

    spad_byte_view #(
        .DATA_W(DATA_W),
        .LOW_W (LOW_W)
    ) u_low (
        .word_in(rd_word),
        .low_out(rd_low)
    );

    // R8: a write is readable at the same address right after its edge.
    p_read_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && (cur_addr == $past(cur_addr)))
        |-> (rd_word == $past(wr_data)));
endmodule

// File: tb/scratch_regfile_test.sv
// Directed bench for scratch_regfile. It keeps its own model of the
// sixteen entries and checks every read against that model.
module scratch_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_sel = 2'd0;
    logic [3:0]  uw_addr = 4'd0;
    logic [15:0] instr = 16'd0;
    logic [15:0] bus_addr = 16'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_word;
    logic [15:0] rd_low;

    logic [15:0] model [16];
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .uw_addr(uw_addr),
        .instr(instr), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_word(rd_word), .rd_low(rd_low)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Select an entry through the microword source and compare both views.
    task automatic peek(input string req, input int idx);
        @(negedge clk);
        wr_en = 1'b0; addr_sel = 2'd0; uw_addr = 4'(idx);
        #1;
        check(req, rd_word, model[idx]);
        check(req, rd_low, {8'h00, model[idx][7:0]});
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) peek(req, i);
    endtask

    // One write cycle with the given source settings.
    task automatic do_write(input logic [1:0] s, input logic [3:0] uw,
                            input logic [15:0] ir, input logic [15:0] ba,
                            input logic [15:0] d);
        @(negedge clk);
        addr_sel = s; uw_addr = uw; instr = ir; bus_addr = ba;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = 16'h0000;
        check_all("R1");
    endtask

    task automatic t_fill_uword;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h1111) ^ 16'h5AC3;
            do_write(2'd0, 4'(i), 16'hFFFF, 16'hFFFF, v);
            model[i] = v;
        end
        check_all("R2/R6");
    endtask

    task automatic t_ir_src;
        logic [15:0] ir;
        ir = 16'hFE00 | (16'd5 << 6) | (16'd7 << 3) | 16'd2;
        @(negedge clk);
        addr_sel = 2'd1; instr = ir; uw_addr = 4'd13; wr_en = 1'b0;
        #1;
        check("R3", rd_word, model[5]);
        do_write(2'd1, 4'd13, ir, 16'hFFFF, 16'hBEEF);
        model[5] = 16'hBEEF;
        peek("R3", 5);
        peek("R3", 13);
    endtask

    task automatic t_ir_dst;
        logic [15:0] ir;
        ir = 16'hFE00 | (16'd3 << 6) | (16'd7 << 3) | 16'd2;
        do_write(2'd2, 4'd5, ir, 16'hFFFF, 16'h1357);
        model[2] = 16'h1357;
        peek("R4", 2);
        peek("R4", 10);
        peek("R4", 3);
    endtask

    task automatic t_bus;
        do_write(2'd3, 4'd1, 16'hFFFF, 16'hFFFE, 16'h2468);
        model[6] = 16'h2468;
        peek("R5", 6);
        peek("R5", 14);
        check_all("R5/R6");
    endtask

    task automatic t_no_write;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            addr_sel = 2'(s); uw_addr = 4'(s + 8); instr = 16'hFFFF;
            bus_addr = 16'h0007; wr_en = 1'b0; wr_data = 16'hDEAD;
            @(posedge clk);
        end
        check_all("R7");
    endtask

    task automatic t_comb_read;
        @(negedge clk);
        addr_sel = 2'd0; uw_addr = 4'd9; wr_en = 1'b1; wr_data = 16'hA5F0;
        #1;
        check("R8", rd_word, model[9]);
        @(posedge clk);
        #1;
        model[9] = 16'hA5F0;
        check("R8", rd_word, 16'hA5F0);
        check("R9", rd_low, 16'h00F0);
        @(negedge clk);
        wr_en = 1'b0;
        uw_addr = 4'd4;
        #1;
        check("R8", rd_word, model[4]);
        check("R9", rd_low, {8'h00, model[4][7:0]});
    endtask

    initial begin
        t_reset();
        t_fill_uword();
        t_ir_src();
        t_ir_dst();
        t_bus();
        t_no_write();
        t_comb_read();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule